// File: doc/BRIEF.md
# Byte-Port Frame Buffer Network Interface

This block is a small network peripheral that holds one incoming frame and one outgoing frame, each at most 1514 bytes. Software talks to it over a simple register bus with an address, a read strobe, a write strobe and 32-bit data in each direction. Frame contents pass through two data ports that move one byte per access and step their own pointers. A busy flag, three interrupt status bits and one level interrupt output tell software when a frame has arrived or left.

On the line side, a byte stream with valid, ready and a last marker delivers whole frames into the receive buffer. A second byte stream with the same handshake carries an outgoing frame as soon as software has written its final byte. A self-test command returns the whole device to its reset state and raises a dedicated status bit that clears when read.

Top module: `framebuf_nic`

## Requirements
- R1: Only address bits [5:0] are decoded. Offset 0x00 reads 0x4D495053 and 0x04 reads 0x4E455430. Offsets 0x18 and 0x20, and every offset with no register, read 0.
- R2: After reset, busy (offset 0x08, bit 0) reads 1. Receive count (0x0C), transmit count (0x10) and interrupt control (0x14) read 0, irq is low, rx_ready is low and tx_valid is low.
- R3: A write to interrupt control (0x14) takes the first matching case in this order: bit 0 set clears TX-done (bit 0), bit 1 set clears RX-done (bit 1), bit 31 set runs the self-test. After the write, busy reads 1 if any status bit remains set and 0 otherwise.
- R4: irq is high exactly while any of bits 0, 1 or 31 of interrupt control is set.
- R5: A read of interrupt control returns its current value and then clears bit 31. Busy is unchanged.
- R6: rx_ready is high only while a frame is in progress, or while busy is 0 and the receive count is below 1514. On the beat marked last, the receive count becomes the frame length, the read pointer returns to the start, busy becomes 1 and RX-done is set.
- R7: Each read of the receive data port (0x1C) returns the next stored byte in bits [7:0] and lowers the receive count by one. When the count is 0, the read returns 0 and changes nothing.
- R8: A frame longer than 1514 bytes is accepted in full on the stream, and only its first 1514 bytes are kept, with a receive count of 1514.
- R9: A write to transmit count (0x10) loads the value if it is at most 1514 and loads 0 otherwise. Either way, the transmit write pointer returns to the start.
- R10: Each write to the transmit data port (0x20) stores bits [7:0]. The write that fills the programmed count sets the transmit count to 0, sets TX-done and busy, and starts the frame on the stream in write order, with tx_last on the final byte.
- R11: A write to the transmit data port is ignored while the transmit count is 0 and while a frame is still being sent.
- R12: A self-test write (bit 31 set, bits 0 and 1 clear) clears both counts and pointers, stops any frame being sent or received, and leaves interrupt control at 0x80000000 and busy at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | BUS_AW | Register address; bits [5:0] are decoded |
| bus_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Marks the final incoming byte of a frame |
| rx_ready | output | 1 | Block can take an incoming byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Marks the final outgoing byte of a frame |
| tx_ready | input | 1 | Sink takes the outgoing byte |

## Verification
A wrong pointer in either buffer appears on the ports one access later, as a wrong byte at the receive data port or on tx_data, or as a frame that ends early or never ends. A wrong busy or status bit appears in the same cycle on rx_ready and irq, because both come straight from those registers. Count errors appear on the next read of the count registers. The bench therefore checks every byte of every frame and reads the counts and status back after each step. It also sends a frame at the truncation limit and checks that reception stays blocked while the receive count is full.

// File: rtl/fbn_pkg.sv
package fbn_pkg;
  localparam int unsigned OFS_W = 6;

  localparam logic [OFS_W-1:0] OFS_ID0   = 6'h00;
  localparam logic [OFS_W-1:0] OFS_ID1   = 6'h04;
  localparam logic [OFS_W-1:0] OFS_BUSY  = 6'h08;
  localparam logic [OFS_W-1:0] OFS_RXCNT = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_TXCNT = 6'h10;
  localparam logic [OFS_W-1:0] OFS_CTL   = 6'h14;
  localparam logic [OFS_W-1:0] OFS_INFO  = 6'h18;
  localparam logic [OFS_W-1:0] OFS_RXDAT = 6'h1C;
  localparam logic [OFS_W-1:0] OFS_TXDAT = 6'h20;

  localparam logic [31:0] ID_WORD0 = 32'h4D495053;
  localparam logic [31:0] ID_WORD1 = 32'h4E455430;

  // Interrupt status: test -> bit 31, rx_done -> bit 1, tx_done -> bit 0
  typedef struct packed {
    logic test;
    logic rx_done;
    logic tx_done;
  } ctl_t;
endpackage

// File: rtl/fbn_rx_store.sv
module fbn_rx_store #(
  parameter int FRAME_MAX = 1514,
  parameter int CW        = $clog2(FRAME_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          open_i,
  input  logic          s_valid_i,
  input  logic [7:0]    s_data_i,
  input  logic          s_last_i,
  output logic          s_ready_o,
  input  logic          pop_i,
  output logic [CW-1:0] count_o,
  output logic [7:0]    byte_o,
  output logic          done_o
);
  logic          active_q, active_d;
  logic [CW-1:0] wptr_q, wptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] rptr_q, rptr_d;
  logic [7:0]    mem [FRAME_MAX];
  logic          beat;
  logic          room;

  assign s_ready_o = active_q | open_i;
  assign beat      = s_valid_i & s_ready_o;
  assign room      = wptr_q < CW'(FRAME_MAX);
  assign count_o   = cnt_q;
  assign byte_o    = mem[rptr_q];

  always_comb begin
    active_d = active_q;
    wptr_d   = wptr_q;
    cnt_d    = cnt_q;
    rptr_d   = rptr_q;
    done_o   = 1'b0;
    if (clr_i) begin
      active_d = 1'b0;
      wptr_d   = '0;
      cnt_d    = '0;
      rptr_d   = '0;
    end else begin
      if (pop_i && cnt_q != '0) begin
        cnt_d  = cnt_q - CW'(1);
        rptr_d = rptr_q + CW'(1);
      end
      if (beat) begin
        if (room) wptr_d = wptr_q + CW'(1);
        if (s_last_i) begin
          done_o   = 1'b1;
          active_d = 1'b0;
          wptr_d   = '0;
          rptr_d   = '0;
          cnt_d    = room ? wptr_q + CW'(1) : wptr_q;
        end else begin
          active_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (beat && room && !clr_i) mem[wptr_q] <= s_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wptr_q   <= '0;
      cnt_q    <= '0;
      rptr_q   <= '0;
    end else begin
      active_q <= active_d;
      wptr_q   <= wptr_d;
      cnt_q    <= cnt_d;
      rptr_q   <= rptr_d;
    end
  end

  // R8: stored length never passes the buffer size
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FRAME_MAX));

  // R7: a read of a non-empty buffer lowers the count by one
  a_r7_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && cnt_q != '0 && !done_o && !clr_i) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/fbn_tx_store.sv
module fbn_tx_store #(
  parameter int FRAME_MAX = 1514,
  parameter int CW        = $clog2(FRAME_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          cnt_wr_i,
  input  logic [31:0]   cnt_val_i,
  input  logic          dat_wr_i,
  input  logic [7:0]    dat_i,
  output logic [CW-1:0] count_o,
  output logic          sent_o,
  output logic          m_valid_o,
  output logic [7:0]    m_data_o,
  output logic          m_last_o,
  input  logic          m_ready_i
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] wptr_q, wptr_d;
  logic [CW-1:0] eptr_q, eptr_d;
  logic [CW-1:0] elen_q, elen_d;
  logic          emit_q, emit_d;
  logic [7:0]    mem [FRAME_MAX];
  logic          store;

  assign store     = dat_wr_i & ~emit_q & (cnt_q != '0) & ~clr_i;
  assign count_o   = cnt_q;
  assign m_valid_o = emit_q;
  assign m_data_o  = mem[eptr_q];
  assign m_last_o  = emit_q && (eptr_q == elen_q - CW'(1));

  always_comb begin
    cnt_d  = cnt_q;
    wptr_d = wptr_q;
    eptr_d = eptr_q;
    elen_d = elen_q;
    emit_d = emit_q;
    sent_o = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      wptr_d = '0;
      eptr_d = '0;
      elen_d = '0;
      emit_d = 1'b0;
    end else begin
      if (emit_q && m_ready_i) begin
        if (m_last_o) emit_d = 1'b0;
        else          eptr_d = eptr_q + CW'(1);
      end
      if (cnt_wr_i) begin
        cnt_d  = (cnt_val_i <= 32'(FRAME_MAX)) ? cnt_val_i[CW-1:0] : '0;
        wptr_d = '0;
      end else if (store) begin
        if (wptr_q + CW'(1) == cnt_q) begin
          sent_o = 1'b1;
          emit_d = 1'b1;
          eptr_d = '0;
          elen_d = cnt_q;
          cnt_d  = '0;
          wptr_d = '0;
        end else begin
          wptr_d = wptr_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem[wptr_q] <= dat_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wptr_q <= '0;
      eptr_q <= '0;
      elen_q <= '0;
      emit_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wptr_q <= wptr_d;
      eptr_q <= eptr_d;
      elen_q <= elen_d;
      emit_q <= emit_d;
    end
  end

  // R10: a stalled byte holds on the stream
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i && !clr_i) |=> (m_valid_o && $stable(m_data_o)));

  // R11: data writes during emission leave the write pointer alone
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr_i && emit_q && !cnt_wr_i && !clr_i) |=> wptr_q == $past(wptr_q));

  // R11: the write pointer stays below a nonzero count
  a_r11_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) || (wptr_q < cnt_q));
endmodule

// File: rtl/framebuf_nic.sv
module framebuf_nic #(
  parameter int FRAME_MAX = 1514,
  parameter int BUS_AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready
);
  import fbn_pkg::*;

  localparam int CW = $clog2(FRAME_MAX + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic [OFS_W-1:0] off;
  ctl_t             ctl_q, ctl_d;
  logic             busy_q, busy_d;
  logic             soft_clr;
  logic             ctl_wr;
  logic             rx_pop, rx_open, rx_done;
  logic [CW-1:0]    rx_cnt, tx_cnt;
  logic [7:0]       rx_byte;
  logic             tx_sent;
  logic [31:0]      ctl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign off      = bus_addr[OFS_W-1:0];
  assign ctl_wr   = bus_wr && off == OFS_CTL;
  assign soft_clr = ctl_wr && !bus_wdata[0] && !bus_wdata[1] && bus_wdata[31];
  assign rx_pop   = bus_rd && off == OFS_RXDAT;
  assign rx_open  = !busy_q && rx_cnt < CW'(FRAME_MAX);
  assign ctl_word = {ctl_q.test, 29'b0, ctl_q.rx_done, ctl_q.tx_done};
  assign irq      = |ctl_q;

  fbn_rx_store #(.FRAME_MAX(FRAME_MAX), .CW(CW)) i_rx (
    .clk(clk), .rst_n(rst_n_int), .clr_i(soft_clr), .open_i(rx_open),
    .s_valid_i(rx_valid), .s_data_i(rx_data), .s_last_i(rx_last),
    .s_ready_o(rx_ready), .pop_i(rx_pop), .count_o(rx_cnt),
    .byte_o(rx_byte), .done_o(rx_done)
  );

  fbn_tx_store #(.FRAME_MAX(FRAME_MAX), .CW(CW)) i_tx (
    .clk(clk), .rst_n(rst_n_int), .clr_i(soft_clr),
    .cnt_wr_i(bus_wr && off == OFS_TXCNT), .cnt_val_i(bus_wdata),
    .dat_wr_i(bus_wr && off == OFS_TXDAT), .dat_i(bus_wdata[7:0]),
    .count_o(tx_cnt), .sent_o(tx_sent),
    .m_valid_o(tx_valid), .m_data_o(tx_data), .m_last_o(tx_last),
    .m_ready_i(tx_ready)
  );

  always_comb begin
    case (off)
      OFS_ID0:   bus_rdata = ID_WORD0;
      OFS_ID1:   bus_rdata = ID_WORD1;
      OFS_BUSY:  bus_rdata = {31'b0, busy_q};
      OFS_RXCNT: bus_rdata = 32'(rx_cnt);
      OFS_TXCNT: bus_rdata = 32'(tx_cnt);
      OFS_CTL:   bus_rdata = ctl_word;
      OFS_RXDAT: bus_rdata = (rx_cnt != '0) ? {24'b0, rx_byte} : 32'b0;
      default:   bus_rdata = 32'b0;
    endcase
  end

  always_comb begin
    ctl_d  = ctl_q;
    busy_d = busy_q;
    if (bus_rd && off == OFS_CTL) ctl_d.test = 1'b0;
    if (ctl_wr) begin
      if (bus_wdata[0])       ctl_d.tx_done = 1'b0;
      else if (bus_wdata[1])  ctl_d.rx_done = 1'b0;
      else if (bus_wdata[31]) ctl_d = '{test: 1'b1, rx_done: 1'b0, tx_done: 1'b0};
    end
    if (rx_done) ctl_d.rx_done = 1'b1;
    if (tx_sent) ctl_d.tx_done = 1'b1;
    if (ctl_wr)                busy_d = |ctl_d;
    else if (rx_done || tx_sent) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ctl_q  <= '0;
      busy_q <= 1'b1;
    end else begin
      ctl_q  <= ctl_d;
      busy_q <= busy_d;
    end
  end

  // R3: busy mirrors the remaining status bits after a control write
  a_r3_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n_int)
    ctl_wr |=> busy_q == (ctl_q != '0));

  // R6: a completed incoming frame leaves busy and RX-done set
  a_r6_rx_done_flags: assert property (@(posedge clk) disable iff (!rst_n_int)
    rx_done |=> (busy_q && ctl_q.rx_done && irq));

  // R12: self-test leaves only the test bit and empty buffers
  a_r12_selftest: assert property (@(posedge clk) disable iff (!rst_n_int)
    soft_clr |=> (ctl_q.test && !ctl_q.rx_done && !ctl_q.tx_done && busy_q
                  && rx_cnt == '0 && tx_cnt == '0 && !tx_valid));

  // R5: a status read clears the test bit unless a self-test sets it again
  a_r5_read_clears_test: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_rd && off == OFS_CTL && !soft_clr) |=> !ctl_q.test);
endmodule

// File: tb/test_framebuf_nic.sv
module test_framebuf_nic;
  localparam int CLK_PERIOD = 10;
  localparam int FMAX = 1514;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  logic        rx_valid, rx_last, rx_ready;
  logic [7:0]  rx_data;
  logic        tx_valid, tx_last, tx_ready;
  logic [7:0]  tx_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] cap [2048];
  int cap_n = 0;
  int last_cnt = 0;
  int last_pos = -1;
  logic rx_stall;

  always #(CLK_PERIOD/2) clk = ~clk;

  framebuf_nic #(.FRAME_MAX(FMAX), .BUS_AW(8)) i_framebuf_nic (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  // R1 vectors: {address, expected read value}
  localparam logic [39:0] RD_VEC [10] = '{
    {8'h00, 32'h4D495053}, {8'h04, 32'h4E455430},
    {8'h40, 32'h4D495053}, {8'hC4, 32'h4E455430},
    {8'h18, 32'h0}, {8'h20, 32'h0}, {8'h24, 32'h0},
    {8'h3C, 32'h0}, {8'h58, 32'h0}, {8'h02, 32'h0}
  };

  always @(negedge clk) begin
    if (tx_valid && tx_ready && cap_n < 2048) begin
      cap[cap_n] = tx_data;
      if (tx_last) begin
        last_cnt = last_cnt + 1;
        last_pos = cap_n;
      end
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(a, d);
    check(d, exp, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic send_rx(input int len, input logic [7:0] base);
    rx_stall = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = base + 8'(i); rx_last = (i == len - 1);
      #1 if (!rx_ready) rx_stall = 1'b1;
      @(posedge clk);
    end
    #1 rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic clear_cap();
    cap_n = 0; last_cnt = 0; last_pos = -1;
  endtask

  task automatic wait_tx(input int n);
    for (int i = 0; i < 200 && cap_n < n; i++) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    rx_valid = 0; rx_data = '0; rx_last = 0; tx_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2 reset state
    check({31'b0, irq}, 0, "R2 irq");
    check({31'b0, rx_ready}, 0, "R2 rx_ready");
    check({31'b0, tx_valid}, 0, "R2 tx_valid");
    rd_chk(8'h08, 1, "R2 busy");
    rd_chk(8'h0C, 0, "R2 rx count");
    rd_chk(8'h10, 0, "R2 tx count");
    rd_chk(8'h14, 0, "R2 status");

    // R1 table walk
    for (int i = 0; i < 10; i++) rd_chk(RD_VEC[i][39:32], RD_VEC[i][31:0], "R1 decode");

    // R3 write of zero clears busy; R12/R4/R5 self-test bit
    wr(8'h14, 0);
    rd_chk(8'h08, 0, "R3 busy after zero write");
    wr(8'h14, 32'h8000_0000);
    rd_chk(8'h08, 1, "R12 busy after self-test");
    check({31'b0, irq}, 1, "R4 irq with test bit");
    rd_chk(8'h14, 32'h8000_0000, "R5 first status read");
    rd_chk(8'h14, 0, "R5 test bit cleared by read");
    check({31'b0, irq}, 0, "R4 irq after read clear");
    rd_chk(8'h08, 1, "R5 busy kept after read");
    wr(8'h14, 0);
    check({31'b0, rx_ready}, 1, "R6 ready when idle");

    // R6/R7 receive frame of 5 bytes
    send_rx(5, 8'h10);
    check({31'b0, rx_stall}, 0, "R6 no stall during frame");
    check({31'b0, rx_ready}, 0, "R6 ready low once busy");
    check({31'b0, irq}, 1, "R4 irq on rx done");
    rd_chk(8'h14, 2, "R6 rx done bit");
    rd_chk(8'h0C, 5, "R6 rx count");
    for (int i = 0; i < 5; i++) begin
      rd_chk(8'h1C, 32'(8'h10 + 8'(i)), "R7 byte order");
      rd_chk(8'h0C, 32'(4 - i), "R7 count step");
    end
    rd_chk(8'h1C, 0, "R7 empty read");
    rd_chk(8'h0C, 0, "R7 empty count kept");

    // R3 priority: bits 0 and 1 set clear only TX-done
    wr(8'h14, 32'h8000_0003);
    rd_chk(8'h14, 2, "R3 bit0 wins over bit1 and bit31");
    rd_chk(8'h08, 1, "R3 busy while bit remains");
    wr(8'h14, 2);
    rd_chk(8'h08, 0, "R3 busy cleared");

    // R9 count loading, R11 write with zero count
    wr(8'h10, 2000);
    rd_chk(8'h10, 0, "R9 oversize count");
    wr(8'h10, 1514);
    rd_chk(8'h10, 1514, "R9 limit count");
    wr(8'h10, 1515);
    rd_chk(8'h10, 0, "R9 one over limit");
    wr(8'h20, 32'h5A);
    rd_chk(8'h14, 0, "R11 zero-count write ignored");

    // R10 transmit 4 bytes, upper bits junk
    clear_cap();
    wr(8'h10, 4);
    wr(8'h20, 32'hABCD_01A5);
    wr(8'h20, 32'h1234_00B6);
    rd_chk(8'h10, 4, "R10 count held mid-frame");
    wr(8'h20, 32'hFFFF_FFC7);
    wr(8'h20, 32'h0000_01D8);
    rd_chk(8'h10, 0, "R10 count cleared after send");
    rd_chk(8'h14, 1, "R10 tx done bit");
    rd_chk(8'h08, 1, "R10 busy set");
    wait_tx(4);
    check(32'(cap_n), 4, "R10 frame length");
    check({24'b0, cap[0]}, 32'hA5, "R10 byte 0");
    check({24'b0, cap[1]}, 32'hB6, "R10 byte 1");
    check({24'b0, cap[2]}, 32'hC7, "R10 byte 2");
    check({24'b0, cap[3]}, 32'hD8, "R10 byte 3");
    check(32'(last_pos), 3, "R10 last marker position");
    check(32'(last_cnt), 1, "R10 single last marker");
    wr(8'h14, 1);

    // R11 writes ignored while emitting
    @(posedge clk); #1 tx_ready = 1'b0;
    clear_cap();
    wr(8'h10, 3);
    wr(8'h20, 32'h11); wr(8'h20, 32'h22); wr(8'h20, 32'h33);
    check({31'b0, tx_valid}, 1, "R10 valid while stalled");
    check({24'b0, tx_data}, 32'h11, "R10 first byte held");
    wr(8'h10, 2);
    wr(8'h20, 32'h99);
    rd_chk(8'h10, 2, "R11 count kept, write ignored");
    @(posedge clk); #1 tx_ready = 1'b1;
    wait_tx(3);
    check(32'(cap_n), 3, "R11 first frame length");
    check({24'b0, cap[0]}, 32'h11, "R11 buffer not overwritten");
    check({24'b0, cap[2]}, 32'h33, "R11 last byte");
    clear_cap();
    wr(8'h20, 32'h44); wr(8'h20, 32'h55);
    wait_tx(2);
    check(32'(cap_n), 2, "R11 pointer not advanced");
    check({24'b0, cap[0]}, 32'h44, "R11 second frame byte 0");
    check({24'b0, cap[1]}, 32'h55, "R11 second frame byte 1");
    wr(8'h14, 1);
    rd_chk(8'h08, 0, "R3 busy after tx ack");

    // R8 truncation, R6 count gate
    send_rx(1600, 8'h30);
    check({31'b0, rx_stall}, 0, "R8 long frame fully taken");
    rd_chk(8'h0C, 1514, "R8 truncated count");
    wr(8'h14, 2);
    check({31'b0, rx_ready}, 0, "R6 full buffer blocks ready");
    rd_chk(8'h1C, 32'h30, "R7 first byte of long frame");
    check({31'b0, rx_ready}, 1, "R6 ready once below limit");
    rd_chk(8'h0C, 1513, "R7 count after one read");

    // R12 self-test clears partial state
    wr(8'h10, 5);
    wr(8'h20, 32'hE1); wr(8'h20, 32'hE2);
    wr(8'h14, 32'h8000_0000);
    rd_chk(8'h0C, 0, "R12 rx count cleared");
    rd_chk(8'h10, 0, "R12 tx count cleared");
    rd_chk(8'h08, 1, "R12 busy");
    check({31'b0, rx_ready}, 0, "R12 ready low");
    rd_chk(8'h14, 32'h8000_0000, "R12 status");
    clear_cap();
    wr(8'h10, 1);
    wr(8'h20, 32'h77);
    wait_tx(1);
    check(32'(cap_n), 1, "R12 tx pointer cleared");
    check({24'b0, cap[0]}, 32'h77, "R12 byte after self-test");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule